// File: doc/BRIEF.md
# Scan Path Select Register

This block holds the number of the scan chain that a test access port routes between its serial input and output. Test software first loads the chain-select instruction. It then walks the data-register path: a capture loads a fixed marker pattern, shifts bring the wanted chain number in from the serial input, and an update commits that number. The committed number drives the chain multiplexer for all later boundary and internal test accesses, until another chain-select update replaces it.

The shift stage and the committed number are two separate registers. The number seen by the multiplexer therefore stays fixed while new bits move through the stage. The stage's low bit leaves on the serial output. That output is retimed on the falling clock edge, so the next device in the chain can sample it on the rising edge. Strobes have no effect unless the chain-select instruction is active.

Top module: `scan_path_select`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising `tck` edge), `chain_sel` is 3 and the shift stage is all zeros, so `tdo` reads 0.
- R2: A capture strobe with `sel_active` high loads the 5-bit stage with binary 10000: bit 4 set, all other bits clear. Shifted out low bit first, the pattern appears on `tdo` as 0,0,0,0,1.
- R3: A shift strobe with `sel_active` high moves the stage one place toward bit 0 and places `tdi` in bit 4. Bit 0 is presented on `tdo`, so a chain number is sent low bit first.
- R4: `tdo` changes only on the falling edge of `tck`. It reflects the stage's bit 0 as it stood after the preceding rising edge.
- R5: An update strobe with `sel_active` high copies the whole stage into `chain_sel`.
- R6: `chain_sel` holds its value through captures, shifts and idle cycles. It changes only on a selected update or on reset.
- R7: While `sel_active` is low, capture, shift and update strobes leave both the stage and `chain_sel` unchanged.
- R8: When several strobes are high in the same cycle, capture wins over shift, and shift wins over update. A losing update does not change `chain_sel`.
- R9: Every 5-bit chain number from 0 to 31 can be committed, including the extremes 0 and 31.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test logic reset |
| tdi | input | 1 | Serial data in |
| sel_active | input | 1 | Chain-select instruction is the current instruction |
| capture_dr | input | 1 | Capture strobe for the data-register path |
| shift_dr | input | 1 | Shift strobe for the data-register path |
| update_dr | input | 1 | Update strobe for the data-register path |
| tdo | output | 1 | Serial data out, changed on falling `tck` |
| chain_sel | output | 5 | Committed scan chain number |

## Verification
The hardest case to reach is showing that strobes given while the instruction is inactive leave the shift stage untouched. The stage is not a port, so its contents are only visible once they are shifted out. The stimulus first parks a known number in the stage and commits it. It then pulses every strobe with `sel_active` low. After that it selects again and shifts without a new capture, so the old contents appear bit by bit on `tdo`. Overlapping strobes are applied in the same way, followed by a shift-out, to expose which action won.

// File: rtl/scan_sel_pkg.sv
package scan_sel_pkg;

    localparam int SS_DEF_WIDTH = 5;
    localparam int SS_DEF_RESET_CHAIN = 3;

    typedef enum logic [1:0] {
        SS_HOLD    = 2'd0,
        SS_CAPTURE = 2'd1,
        SS_SHIFT   = 2'd2,
        SS_UPDATE  = 2'd3
    } ss_op_e;

    // Ordering of overlapping strobes: capture, then shift, then update.
    function automatic ss_op_e ss_pick_op(input logic en, input logic cap,
                                          input logic sh, input logic upd);
        if (!en)  return SS_HOLD;
        if (cap)  return SS_CAPTURE;
        if (sh)   return SS_SHIFT;
        if (upd)  return SS_UPDATE;
        return SS_HOLD;
    endfunction

endpackage

// File: rtl/scan_sel_decode.sv
module scan_sel_decode
    import scan_sel_pkg::*;
(
    input  logic   sel_active,
    input  logic   capture_dr,
    input  logic   shift_dr,
    input  logic   update_dr,
    output ss_op_e op
);

    always_comb begin
        op = ss_pick_op(sel_active, capture_dr, shift_dr, update_dr);
    end

endmodule

// File: rtl/scan_sel_stage.sv
module scan_sel_stage
    import scan_sel_pkg::*;
#(
    parameter int WIDTH = SS_DEF_WIDTH
) (
    input  logic             tck,
    input  logic             rst,
    input  ss_op_e           op,
    input  logic             tdi,
    output logic [WIDTH-1:0] stage_q
);

    // Marker pattern: only the top bit set.
    localparam logic [WIDTH-1:0] MARKER = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] shifted;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == WIDTH - 1) begin : g_top
            assign shifted[i] = tdi;
        end else begin : g_mid
            assign shifted[i] = stage_q[i+1];
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            case (op)
                SS_CAPTURE: stage_q <= MARKER;
                SS_SHIFT:   stage_q <= shifted;
                default:    stage_q <= stage_q;
            endcase
        end
    end

endmodule

// File: rtl/scan_sel_hold.sv
module scan_sel_hold
    import scan_sel_pkg::*;
#(
    parameter int WIDTH       = SS_DEF_WIDTH,
    parameter int RESET_CHAIN = SS_DEF_RESET_CHAIN
) (
    input  logic             tck,
    input  logic             rst,
    input  ss_op_e           op,
    input  logic [WIDTH-1:0] stage_q,
    output logic [WIDTH-1:0] chain_q
);

    localparam logic [WIDTH-1:0] RESET_VAL = WIDTH'(RESET_CHAIN);

    always_ff @(posedge tck) begin
        if (rst) begin
            chain_q <= RESET_VAL;
        end else if (op == SS_UPDATE) begin
            chain_q <= stage_q;
        end
    end

endmodule

// File: rtl/scan_sel_retime.sv
module scan_sel_retime (
    input  logic tck,
    input  logic bit_in,
    output logic bit_out
);

    // Falling-edge launch gives the downstream device half a cycle of setup.
    always_ff @(negedge tck) begin
        bit_out <= bit_in;
    end

endmodule

// File: rtl/scan_path_select.sv
module scan_path_select
    import scan_sel_pkg::*;
#(
    parameter int WIDTH       = SS_DEF_WIDTH,
    parameter int RESET_CHAIN = SS_DEF_RESET_CHAIN
) (
    input  logic             tck,
    input  logic             rst,
    input  logic             tdi,
    input  logic             sel_active,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    output logic             tdo,
    output logic [WIDTH-1:0] chain_sel
);

    ss_op_e           op;
    logic [WIDTH-1:0] stage_q;

    scan_sel_decode u_decode (
        .sel_active (sel_active),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .op         (op)
    );

    scan_sel_stage #(.WIDTH(WIDTH)) u_stage (
        .tck     (tck),
        .rst     (rst),
        .op      (op),
        .tdi     (tdi),
        .stage_q (stage_q)
    );

    scan_sel_hold #(.WIDTH(WIDTH), .RESET_CHAIN(RESET_CHAIN)) u_hold (
        .tck     (tck),
        .rst     (rst),
        .op      (op),
        .stage_q (stage_q),
        .chain_q (chain_sel)
    );

    scan_sel_retime u_retime (
        .tck     (tck),
        .bit_in  (stage_q[0]),
        .bit_out (tdo)
    );

endmodule

// File: rtl/scan_sel_checker.sv
module scan_sel_checker #(
    parameter int WIDTH       = 5,
    parameter int RESET_CHAIN = 3
) (
    input logic             tck,
    input logic             rst,
    input logic             tdi,
    input logic             sel_active,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic             update_dr,
    input logic             tdo,
    input logic [WIDTH-1:0] chain_sel,
    input logic [WIDTH-1:0] stage_q
);

    localparam logic [WIDTH-1:0] MARKER    = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] RESET_VAL = WIDTH'(RESET_CHAIN);

    logic rst_seen = 1'b0;

    always_ff @(posedge tck) begin
        rst_seen <= rst;
        if (rst_seen) begin
            a_r1_reset_chain: assert (chain_sel == RESET_VAL && stage_q == '0)
                else $error("R1: reset values wrong");
        end
    end

    a_r2_capture_marker: assert property (@(posedge tck) disable iff (rst)
        (sel_active && capture_dr) |=> (stage_q == MARKER));

    a_r3_shift_lsb_first: assert property (@(posedge tck) disable iff (rst)
        (sel_active && !capture_dr && shift_dr)
        |=> (stage_q == {$past(tdi), $past(stage_q[WIDTH-1:1])}));

    a_r4_tdo_follows_stage: assert property (@(posedge tck) disable iff (rst)
        tdo == stage_q[0]);

    a_r5_update_commits: assert property (@(posedge tck) disable iff (rst)
        (sel_active && !capture_dr && !shift_dr && update_dr)
        |=> (chain_sel == $past(stage_q)));

    a_r6_chain_holds: assert property (@(posedge tck) disable iff (rst)
        !(sel_active && !capture_dr && !shift_dr && update_dr)
        |=> $stable(chain_sel));

    a_r7_inactive_ignored: assert property (@(posedge tck) disable iff (rst)
        !sel_active |=> ($stable(stage_q) && $stable(chain_sel)));

endmodule

bind scan_path_select scan_sel_checker #(.WIDTH(WIDTH), .RESET_CHAIN(RESET_CHAIN)) u_chk (
    .tck        (tck),
    .rst        (rst),
    .tdi        (tdi),
    .sel_active (sel_active),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .tdo        (tdo),
    .chain_sel  (chain_sel),
    .stage_q    (stage_q)
);

// File: tb/scan_path_select_bench.sv
module scan_path_select_bench;

    localparam int W = 5;

    typedef struct {
        logic         tdo;
        logic [W-1:0] ch;
        string        tag;
    } exp_t;

    logic         tck = 1'b0;
    logic         rst = 1'b1;
    logic         tdi = 1'b0;
    logic         sel_active = 1'b0;
    logic         capture_dr = 1'b0;
    logic         shift_dr = 1'b0;
    logic         update_dr = 1'b0;
    logic         tdo;
    logic [W-1:0] chain_sel;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    exp_t q[$];

    logic [W-1:0] m_stage = '0;
    logic [W-1:0] m_chain = 5'd3;

    always #10 tck = ~tck;

    scan_path_select u_scan_path_select (
        .tck(tck), .rst(rst), .tdi(tdi), .sel_active(sel_active),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdo(tdo), .chain_sel(chain_sel)
    );

    task automatic step(input logic r, input logic s, input logic c,
                        input logic sh, input logic u, input logic d,
                        input string tag);
        exp_t e;
        @(posedge tck);
        #2;
        rst = r; sel_active = s; capture_dr = c; shift_dr = sh;
        update_dr = u; tdi = d;
        if (r) begin
            m_stage = '0;
            m_chain = 5'd3;
        end else if (s) begin
            if (c)       m_stage = 5'b10000;
            else if (sh) m_stage = {d, m_stage[W-1:1]};
            else if (u)  m_chain = m_stage;
        end
        e.tdo = m_stage[0];
        e.ch  = m_chain;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic load_chain(input logic [W-1:0] v, input string tag);
        step(0, 1, 1, 0, 0, 0, tag);
        for (int i = 0; i < W; i++) step(0, 1, 0, 1, 0, v[i], tag);
        step(0, 1, 0, 0, 1, 0, tag);
    endtask

    // Monitor: pop each expected item and compare after the falling edge.
    initial begin
        exp_t e;
        logic prev_tdo;
        bit   prev_ok;
        prev_ok = 0;
        prev_tdo = 1'b0;
        forever begin
            @(posedge tck);
            if (q.size() > 0) begin
                e = q.pop_front();
                #3;
                if (prev_ok) begin
                    tests++;
                    if (tdo !== prev_tdo) begin
                        fails++;
                        $display("FAIL R4 tdo moved at rising edge (%s): got %b exp %b",
                                 e.tag, tdo, prev_tdo);
                    end
                end
                @(negedge tck);
                #3;
                tests++;
                if (tdo !== e.tdo || chain_sel !== e.ch) begin
                    fails++;
                    $display("FAIL %s: tdo=%b chain=%0d exp tdo=%b chain=%0d",
                             e.tag, tdo, chain_sel, e.tdo, e.ch);
                end
                prev_tdo = e.tdo;
                prev_ok = 1;
            end
        end
    end

    initial begin
        step(1, 0, 0, 0, 0, 0, "R1 reset");
        step(1, 0, 0, 0, 0, 0, "R1 reset");
        // R2 marker out LSB first, R3 new number in, R5 commit, R6 hold during shift
        step(0, 1, 1, 0, 0, 0, "R2 capture");
        for (int i = 0; i < W; i++) step(0, 1, 0, 1, 0, 5'd7 >> i, "R2 R3 R6 shift");
        step(0, 1, 0, 0, 1, 0, "R5 update to 7");
        for (int i = 0; i < 3; i++) idle("R6 hold idle");
        // R7: strobes with select inactive, then expose stage by shifting
        step(0, 0, 1, 0, 0, 0, "R7 capture ignored");
        step(0, 0, 0, 1, 0, 1, "R7 shift ignored");
        step(0, 0, 0, 0, 1, 0, "R7 update ignored");
        for (int i = 0; i < W; i++) step(0, 1, 0, 1, 0, 0, "R7 stage intact");
        // R8: overlapping strobes
        load_chain(5'd9, "R8 setup");
        step(0, 1, 1, 1, 1, 1, "R8 capture wins");
        step(0, 1, 0, 1, 1, 1, "R8 shift beats update");
        for (int i = 0; i < W - 1; i++) step(0, 1, 0, 1, 0, 0, "R8 reveal");
        step(0, 1, 0, 0, 1, 0, "R8 update alone");
        // R9 extremes
        load_chain(5'd31, "R9 chain 31");
        idle("R9 hold 31");
        load_chain(5'd0, "R9 chain 0");
        load_chain(5'd21, "R9 chain 21");
        // R1 reset in the middle of a shift
        step(0, 1, 1, 0, 0, 0, "R1 pre-reset");
        step(0, 1, 0, 1, 0, 1, "R1 pre-reset");
        step(1, 1, 0, 1, 0, 1, "R1 mid reset");
        for (int i = 0; i < W; i++) step(0, 1, 0, 1, 0, 0, "R1 stage cleared");
        idle("R1 chain 3 after reset");
        repeat (4) @(posedge tck);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule